// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer with Compare Interrupt

This block is a 32-bit interval timer that sits on a simple register bus (one write strobe, one read strobe, a 3-bit word address and 32-bit data). Software picks one of three tick-enable inputs, or none, and sets a divider ratio. The block then decrements a live count by one for every divided tick while it is enabled.

At zero the count either reloads from a software-written load value or wraps to all ones. A compare register is matched against the live count. A match raises a sticky status flag, and that flag drives a level interrupt.

Software can also do the following:
- Force the live count from the load register through an overwrite option.
- Choose whether enabling restarts the count or resumes it.
- Issue a soft reset that keeps the enable-related control bits.

Top module: `cmpdn_timer`

## Requirements
- R1: After hardware reset the control, status and compare registers read 0, load and count read 32'hFFFF_FFFF, and irq is 0.
- R2: Word addresses are 0 = control, 1 = status, 2 = load, 3 = compare and 4 = count. Count is read-only. Addresses 5 to 7 read as 0, and writes to them or to address 4 change nothing. rdata is 0 whenever rd_en is low.
- R3: A control write stores wdata[25:0], except bit 16, which always reads 0. Bits 31:26 always read 0. Bit 0 = enable, bit 1 = start-mode, bit 2 = compare-irq-enable, bit 3 = reload mode, bits 15:4 = divider, bit 17 = overwrite, bits 21:18 = kept low-power bits, bits 25:24 = tick select.
- R4: Tick select works as follows: 00 selects no tick, 01 tick_periph, 10 tick_fast and 11 tick_slow. While enable is set, the count moves once for every (divider+1) selected ticks. With select 00 the count does not move. A control change takes effect from the cycle after the write.
- R5: A step taken at count 0 loads the load value when reload mode is 1, and loads 32'hFFFF_FFFF when it is 0.
- R6: A control write that takes enable from 0 to 1 with start-mode set makes the count equal to load if the written reload bit is 1, and 32'hFFFF_FFFF otherwise. With start-mode clear, the count keeps its value.
- R7: While enable is 0 the count holds its value, apart from writes.
- R8: A control write with bit 16 set keeps only the written bits 0, 1 and 21:18 and clears every other control bit. It also clears status and compare, and sets load and count to 32'hFFFF_FFFF.
- R9: A load write while the stored overwrite bit is 1 sets the count to the written value in the next cycle.
- R10: Status bit 0 is set in the cycle after a cycle in which enable and compare-irq-enable are 1 and count equals compare.
- R11: Writing status with wdata[0] = 1 clears bit 0, and writing it with wdata[0] = 0 has no effect. If a match occurs in the same cycle as the clearing write, the flag stays set.
- R12: irq is 1 exactly when status bit 0, compare-irq-enable and enable are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational in the read cycle |
| tick_periph | input | 1 | Tick enable, source 01 |
| tick_fast | input | 1 | Tick enable, source 10 |
| tick_slow | input | 1 | Tick enable, source 11 |
| irq | output | 1 | Level compare interrupt |

## Verification
A corrupted divider phase or count shows up at the count address within one divided period, because every read is compared against a cycle-exact model. A wrong reload or wrap choice shows up on the first read after the count crosses zero. A wrong flag shows up on irq in the cycle after the match or the clearing write. The same holds for a wrong compare value, because irq is compared against the model in every cycle. Soft-reset and start-mode errors show up at the first read of control, load or count after the write. The random phase uses small load, compare and divider values so that zero crossings and matches happen many times.

// File: rtl/cmpdn_timer.sv
module cmpdn_timer #(
  parameter int PSC_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        tick_periph,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        irq
);
  localparam int CTRL_W = 26;
  localparam int PSC_LO = 4;
  localparam int PSC_HI = PSC_LO + PSC_W - 1;
  localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h03C_0003;
  localparam logic [31:0] ALL_ONES = '1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic [31:0]       load_q, cmp_q, cnt_q;
  logic [PSC_W-1:0]  pre_q;

  logic en_q, smode_q, cie_q, rld_q, ovw_q;
  logic [PSC_W-1:0] psc_q;
  logic [1:0] sel_q;

  assign en_q    = ctrl_q[0];
  assign smode_q = ctrl_q[1];
  assign cie_q   = ctrl_q[2];
  assign rld_q   = ctrl_q[3];
  assign psc_q   = ctrl_q[PSC_HI:PSC_LO];
  assign ovw_q   = ctrl_q[17];
  assign sel_q   = ctrl_q[25:24];

  logic tick, step, match;
  logic wr_ctrl, wr_stat, wr_load, wr_cmp, soft_rst, start;

  always_comb begin
    case (sel_q)
      2'b01:   tick = tick_periph;
      2'b10:   tick = tick_fast;
      2'b11:   tick = tick_slow;
      default: tick = 1'b0;
    endcase
  end

  assign step     = en_q && tick && (pre_q >= psc_q);
  assign match    = en_q && cie_q && (cnt_q == cmp_q);
  assign wr_ctrl  = wr_en && (addr == 3'd0);
  assign wr_stat  = wr_en && (addr == 3'd1);
  assign wr_load  = wr_en && (addr == 3'd2);
  assign wr_cmp   = wr_en && (addr == 3'd3);
  assign soft_rst = wr_ctrl && wdata[16];
  assign start    = wr_ctrl && !wdata[16] && !en_q && wdata[0] && wdata[1];
  assign irq      = flag_q && cie_q && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_q <= '0;
    else if (!en_q || soft_rst || step)
      pre_q <= '0;
    else if (tick)
      pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= wdata[CTRL_W-1:0] & KEEP_MASK;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= {wdata[25:17], 1'b0, wdata[15:0]};
      if (wr_load) load_q <= wdata;
      if (wr_cmp)  cmp_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)
      flag_q <= 1'b0;
    else if (match)
      flag_q <= 1'b1;
    else if (wr_stat && wdata[0])
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)
      cnt_q <= ALL_ONES;
    else if (start)
      cnt_q <= wdata[3] ? load_q : ALL_ONES;
    else if (wr_load && ovw_q)
      cnt_q <= wdata;
    else if (step)
      cnt_q <= (cnt_q == '0) ? (rld_q ? load_q : ALL_ONES) : cnt_q - 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        3'd0:    rdata = {6'b0, ctrl_q};
        3'd1:    rdata = {31'b0, flag_q};
        3'd2:    rdata = load_q;
        3'd3:    rdata = cmp_q;
        3'd4:    rdata = cnt_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

module cmpdn_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        irq,
  input logic        en_q,
  input logic        cie_q,
  input logic        rld_q,
  input logic        ovw_q,
  input logic        flag_q,
  input logic        step,
  input logic [31:0] load_q,
  input logic [31:0] cmp_q,
  input logic [31:0] cnt_q
);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > 3'd4) |-> rdata == 32'd0);

  // R5
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == 32'd0 && !wr_en) |=> cnt_q == ($past(rld_q) ? $past(load_q) : 32'hFFFF_FFFF));

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(wr_en && (addr == 3'd0 || addr == 3'd2))) |=> $stable(cnt_q));

  // R9
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && ovw_q) |=> cnt_q == $past(wdata));

  // R10
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_q && cie_q && cnt_q == cmp_q));

  // R11
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !wdata[0]) |=> !$fell(flag_q));

  // R12
  disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !wdata[0]) |=> !irq);
endmodule

bind cmpdn_timer cmpdn_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .en_q(en_q), .cie_q(cie_q),
  .rld_q(rld_q), .ovw_q(ovw_q), .flag_q(flag_q), .step(step),
  .load_q(load_q), .cmp_q(cmp_q), .cnt_q(cnt_q)
);

// File: tb/cmpdn_timer_bench.sv
`timescale 1ns/1ps
module cmpdn_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tick_periph = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmpdn_timer u_cmpdn_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_periph(tick_periph),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  logic [25:0] m_ctrl;
  logic        m_flag;
  logic [31:0] m_load, m_cmp, m_cnt;
  logic [11:0] m_pre;

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_ctrl};
      3'd1: return {31'b0, m_flag};
      3'd2: return m_load;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R11";
      3'd2: return "R9";
      3'd3: return "R8";
      3'd4: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = '0; m_flag = 1'b0; m_load = '1; m_cmp = '0; m_cnt = '1; m_pre = '0;
  endtask

  task automatic model_step(input logic w, input logic [2:0] a, input logic [31:0] d,
                            input logic [2:0] tk);
    logic en, tick, stp, mt;
    logic [25:0] c_n; logic f_n; logic [31:0] l_n, k_n, n_n; logic [11:0] p_n;
    en = m_ctrl[0];
    case (m_ctrl[25:24])
      2'b01: tick = tk[0];
      2'b10: tick = tk[1];
      2'b11: tick = tk[2];
      default: tick = 1'b0;
    endcase
    stp = 1'b0; p_n = m_pre;
    if (!en) p_n = '0;
    else if (tick) begin
      if (m_pre >= m_ctrl[15:4]) begin p_n = '0; stp = 1'b1; end
      else p_n = m_pre + 1;
    end
    n_n = m_cnt;
    if (stp) n_n = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
    mt = en && m_ctrl[2] && (m_cnt == m_cmp);
    f_n = m_flag | mt;
    c_n = m_ctrl; l_n = m_load; k_n = m_cmp;
    if (w) begin
      case (a)
        3'd0: if (d[16]) begin
                c_n = d[25:0] & 26'h03C_0003; f_n = 1'b0; k_n = '0; l_n = '1; n_n = '1; p_n = '0;
              end else begin
                c_n = d[25:0];
                if (!en && d[0] && d[1]) n_n = d[3] ? m_load : 32'hFFFF_FFFF;
              end
        3'd1: if (d[0]) f_n = mt;
        3'd2: begin l_n = d; if (m_ctrl[17]) n_n = d; end
        3'd3: k_n = d;
        default: ;
      endcase
    end
    m_ctrl = c_n; m_flag = f_n; m_load = l_n; m_cmp = k_n; m_cnt = n_n; m_pre = p_n;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d,
                     input logic [2:0] tk, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    {tick_slow, tick_fast, tick_periph} = tk;
    #1;
    if (r) check(tag, rdata, exp_read(a));
    check("R12", {31'b0, irq}, {31'b0, m_flag & m_ctrl[2] & m_ctrl[0]});
    @(posedge clk);
    model_step(w, a, d, tk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, 3'b000, "W");
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'd0, 3'b000, tag);
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0;
    {tick_slow, tick_fast, tick_periph} = 3'b000;
    #1;
    check(tag, rdata, e);
    check(tag, exp_read(a), e);
    @(posedge clk);
    model_step(1'b0, a, 32'd0, 3'b000);
  endtask

  task automatic idle(input int n, input logic [2:0] tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'd0, tk, "IDLE");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1
    check("R1", {31'b0, irq}, 32'd0);
    rd_exp(3'd0, 32'd0, "R1");
    rd_exp(3'd1, 32'd0, "R1");
    rd_exp(3'd2, 32'hFFFF_FFFF, "R1");
    rd_exp(3'd3, 32'd0, "R1");
    rd_exp(3'd4, 32'hFFFF_FFFF, "R1");

    // R3
    wr(3'd0, 32'hFFFE_FFFE);
    rd_exp(3'd0, 32'h03FE_FFFE, "R3");
    wr(3'd0, 32'd0);

    // R2
    wr(3'd5, 32'h1234_5678);
    rd_exp(3'd5, 32'd0, "R2");
    wr(3'd4, 32'd5);
    rd_exp(3'd4, 32'hFFFF_FFFF, "R2");
    cyc(1'b0, 1'b0, 3'd2, 32'd0, 3'b000, "R2");
    check("R2", rdata, 32'd0);

    // R4
    wr(3'd0, 32'h0100_0021);
    idle(9, 3'b001);
    rd(3'd4, "R4");
    idle(6, 3'b110);
    rd(3'd4, "R4");
    wr(3'd0, 32'h0000_0001);
    idle(5, 3'b111);
    rd(3'd4, "R4");
    wr(3'd0, 32'h0300_0001);
    idle(4, 3'b100);
    rd(3'd4, "R4");

    // R7
    wr(3'd0, 32'h0300_0000);
    idle(6, 3'b111);
    rd(3'd4, "R7");

    // R9 and R5
    wr(3'd0, 32'h0002_0000);
    wr(3'd2, 32'd2);
    rd_exp(3'd4, 32'd2, "R9");
    wr(3'd0, 32'h0102_0001);
    idle(4, 3'b001);
    rd(3'd4, "R5");
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0100_000B);
    idle(5, 3'b001);
    rd(3'd4, "R5");

    // R6
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd7);
    wr(3'd0, 32'h0100_0003);
    rd_exp(3'd4, 32'hFFFF_FFFF, "R6");
    wr(3'd0, 32'h0100_000B);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0100_000B);
    rd_exp(3'd4, 32'd7, "R6");
    idle(3, 3'b001);
    wr(3'd0, 32'h0100_0000);
    wr(3'd0, 32'h0100_0001);
    rd(3'd4, "R6");

    // R10 and R11
    wr(3'd0, 32'h0002_0000);
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'h0000_0005);
    idle(2, 3'b000);
    rd_exp(3'd1, 32'd1, "R10");
    check("R12", {31'b0, irq}, 32'd1);
    wr(3'd1, 32'd1);
    rd_exp(3'd1, 32'd1, "R11");
    wr(3'd3, 32'd9);
    wr(3'd1, 32'd0);
    rd_exp(3'd1, 32'd1, "R11");
    wr(3'd1, 32'd1);
    rd_exp(3'd1, 32'd0, "R11");

    // R12
    wr(3'd3, 32'd5);
    idle(2, 3'b000);
    wr(3'd0, 32'h0000_0001);
    rd_exp(3'd1, 32'd1, "R12");
    check("R12", {31'b0, irq}, 32'd0);

    // R8
    wr(3'd0, 32'h033F_FFFF);
    rd_exp(3'd0, 32'h003C_0003, "R8");
    rd_exp(3'd1, 32'd0, "R8");
    rd_exp(3'd2, 32'hFFFF_FFFF, "R8");
    rd_exp(3'd3, 32'd0, "R8");
    rd_exp(3'd4, 32'hFFFF_FFFF, "R8");

    for (int i = 0; i < 6000; i++) begin
      logic [31:0] d;
      logic [2:0] a;
      logic w, r;
      d = $urandom;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 3) == 0);
      r = !w && ($urandom_range(0, 1) == 1);
      if (w && a == 3'd0) begin
        d[15:6] = '0;
        d[16] = ($urandom_range(0, 15) == 0);
      end
      if (w && (a == 3'd2 || a == 3'd3) && $urandom_range(0, 7) != 0) d = 32'($urandom_range(0, 7));
      cyc(w, r, a, d, 3'($urandom), tag_of(a));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule